// File: doc/BRIEF.md
# Wrapping Burst Address Sequencer

This block sits between an on-chip bus and an external parallel NOR flash or PSRAM. It turns one burst request into the address cycles and beat strobes that the memory sees. A request carries a byte address, a beat count and a flag that marks it as a wrapping burst. The settings sampled with the request select an 8-bit or 16-bit memory, synchronous or asynchronous signalling, whether the memory wraps bursts by itself, and the memory's wrap length of 8 or 16 words. The two top address bits pick one of four banks, each with its own select line. The remaining bits become a word address for the memory.

In asynchronous mode each beat carries its own address, so a wrapping burst is sent as one transaction whose addresses roll over inside the aligned block. In synchronous mode the address goes out once per transaction and the beats follow on consecutive cycles. A synchronous wrapping burst is sent as a single transaction when the memory can wrap it itself or when the start is already aligned. Otherwise it is split into two linear transactions sent back to back. The first runs from the start word to the end of the aligned block, and the second runs from the block base up to the word just before the start. A one-cycle done pulse closes the request.

Top module: `wrap_burst_seq`

## Requirements
- R1: While a request is in progress, exactly one bit of `memBankSel` is high: bit k for `reqAddr[27:26]` equal to k (00 gives bit 0, 11 gives bit 3). In idle all four bits are low.
- R2: With `cfgWide`=0 the word address is `reqAddr[25:0]`. With `cfgWide`=1 it is `reqAddr[25:1]` placed on `memAddr[24:0]`, with `memAddr[25]` low.
- R3: `reqReady` is high only in idle. A request is taken when `reqValid` and `reqReady` are both high, and address and settings are sampled only at that moment. While busy, `reqValid` and any change of the request or setting inputs have no effect.
- R4: Each linear transaction opens with one address cycle (`addrValid` and `txnStart` high, `beatStrobe` low). Its beats follow on the next consecutive cycles, one `beatStrobe` per cycle, and `txnEnd` is high on its last beat.
- R5: With `cfgSync`=1, `addrValid` is high only in address cycles, and `memAddr` holds the transaction's start word through all of its beats.
- R6: With `cfgSync`=0, every beat also raises `addrValid` with its own address. For a non-wrapping request the address is the start word plus the beat index. For a wrapping request of length L (2, 4, 8 or 16) it is block base plus ((start offset + beat index) mod L), where the base is the start word with its low log2(L) bits cleared.
- R7: A synchronous wrapping request whose length equals the memory wrap length (`cfgWrap16`=1 gives 16, 0 gives 8) and has `cfgWrapEn`=1 is sent as one transaction of L beats from the start word.
- R8: Any other synchronous wrapping request with a nonzero start offset is sent as two transactions. The first covers L minus offset beats from the start word. The address cycle of the second follows on the very next cycle at the block base, and the second covers offset beats.
- R9: A synchronous wrapping request whose start word is aligned to L is sent as one transaction of L beats.
- R10: `done` pulses for one cycle, exactly one cycle after the last beat of the final transaction, and `reqReady` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqAddr | input | 28 | Byte address; bits 27:26 choose the bank |
| reqLen | input | 5 | Beats in the burst, 1 to 16 (power of two for wrapping requests) |
| reqWrap | input | 1 | Request is a wrapping burst |
| cfgWide | input | 1 | 1: 16-bit memory, 0: 8-bit memory |
| cfgSync | input | 1 | 1: synchronous signalling, 0: asynchronous |
| cfgWrapEn | input | 1 | Memory wraps bursts by itself |
| cfgWrap16 | input | 1 | Memory wrap length: 1 gives 16 words, 0 gives 8 |
| memAddr | output | 26 | Word address to the memory |
| memBankSel | output | 4 | One-hot bank select |
| addrValid | output | 1 | Address presented this cycle |
| beatStrobe | output | 1 | One data beat this cycle |
| txnStart | output | 1 | Address cycle that opens a linear transaction |
| txnEnd | output | 1 | Last beat of a linear transaction |
| done | output | 1 | Request complete |

## Verification
The checker watches, on every cycle, the one-hot bank select against the busy state and the drop of ready after a request is taken. It also checks that each transaction opens with an address cycle, that a synchronous beat never moves the address, and that every transaction end leads straight into either a second address cycle or the done pulse. The exact word addresses, the width conversion, the choice between one transaction and a split, the beat counts of the two halves and the modulo roll-over of asynchronous wrapping bursts depend on the request values. Only the bench's reference model can show those, across its list of scenarios.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_BEAT,
    ST_SPLIT_ADDR
  } seqState_t;

  typedef struct packed {
    logic load;   // take a new request
    logic step;   // one beat consumed
    logic part2;  // begin second linear transaction
  } ctlStrobes_t;
endpackage

// File: rtl/wbs_datapath.sv
module wbs_datapath
  import wbs_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int BANK_W = 2,
  parameter int LEN_W  = 5,
  localparam int MEM_W = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrap,
  input  logic              cfgWide,
  input  logic              cfgSync,
  input  logic              cfgWrapEn,
  input  logic              cfgWrap16,
  output logic [MEM_W-1:0]  curAddr,
  output logic [BANK_W-1:0] bankQ,
  output logic              lastBeat,
  output logic              splitPend,
  output logic              syncQ
);
  // request decode, evaluated only when a request is taken
  logic [MEM_W-1:0] wordIn;
  logic [LEN_W-1:0] lenM1;
  logic [LEN_W-1:0] offIn;
  logic [LEN_W-1:0] nFull;
  logic             memWraps;
  logic             needSplit;
  logic [LEN_W-1:0] firstCnt;

  always_comb begin
    wordIn    = cfgWide ? {1'b0, reqAddr[MEM_W-1:1]} : reqAddr[MEM_W-1:0];
    lenM1     = reqLen - LEN_W'(1);
    offIn     = wordIn[LEN_W-1:0] & lenM1;
    nFull     = cfgWrap16 ? LEN_W'(16) : LEN_W'(8);
    memWraps  = cfgWrapEn && (reqLen == nFull);
    needSplit = reqWrap && cfgSync && !memWraps && (offIn != '0);
    firstCnt  = needSplit ? (reqLen - offIn) : reqLen;
  end

  // held request state
  logic [LEN_W-1:0] maskQ;
  logic             wrapQ;
  logic [LEN_W-1:0] beatsLeft;
  logic [LEN_W-1:0] part2Cnt;
  logic [MEM_W-1:0] baseQ;
  logic [MEM_W-1:0] maskW;
  logic [MEM_W-1:0] incAddr;
  logic [MEM_W-1:0] nextAddr;

  always_comb begin
    maskW    = MEM_W'(maskQ);
    incAddr  = curAddr + MEM_W'(1);
    nextAddr = wrapQ ? ((curAddr & ~maskW) | (incAddr & maskW)) : incAddr;
    lastBeat = (beatsLeft == LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      bankQ     <= '0;
      maskQ     <= '0;
      wrapQ     <= 1'b0;
      syncQ     <= 1'b0;
      beatsLeft <= '0;
      part2Cnt  <= '0;
      splitPend <= 1'b0;
      baseQ     <= '0;
    end else if (ctl.load) begin
      curAddr   <= wordIn;
      bankQ     <= reqAddr[ADDR_W-1 -: BANK_W];
      maskQ     <= lenM1;
      wrapQ     <= reqWrap;
      syncQ     <= cfgSync;
      beatsLeft <= firstCnt;
      part2Cnt  <= offIn;
      splitPend <= needSplit;
      baseQ     <= wordIn & ~MEM_W'(lenM1);
    end else if (ctl.part2) begin
      curAddr   <= baseQ;
      beatsLeft <= part2Cnt;
      splitPend <= 1'b0;
    end else if (ctl.step) begin
      beatsLeft <= beatsLeft - LEN_W'(1);
      if (!syncQ) curAddr <= nextAddr;
    end
  end
endmodule

// File: rtl/wbs_control.sv
module wbs_control
  import wbs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lastBeat,
  input  logic        splitPend,
  input  logic        syncQ,
  output ctlStrobes_t ctl,
  output logic        reqReady,
  output logic        busy,
  output logic        addrValid,
  output logic        beatStrobe,
  output logic        txnStart,
  output logic        txnEnd,
  output logic        done
);
  seqState_t state, stateNxt;
  logic      doneQ;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.load = 1'b1;
        stateNxt = ST_ADDR;
      end
      ST_ADDR:       stateNxt = ST_BEAT;
      ST_SPLIT_ADDR: stateNxt = ST_BEAT;
      ST_BEAT: begin
        ctl.step = 1'b1;
        if (lastBeat) begin
          if (splitPend) begin
            ctl.part2 = 1'b1;
            stateNxt  = ST_SPLIT_ADDR;
          end else begin
            stateNxt  = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNxt;
      doneQ <= (state == ST_BEAT) && lastBeat && !splitPend;
    end
  end

  always_comb begin
    reqReady   = (state == ST_IDLE);
    busy       = !reqReady;
    txnStart   = (state == ST_ADDR) || (state == ST_SPLIT_ADDR);
    beatStrobe = (state == ST_BEAT);
    addrValid  = txnStart || (beatStrobe && !syncQ);
    txnEnd     = beatStrobe && lastBeat;
    done       = doneQ;
  end
endmodule

// File: rtl/wrap_burst_seq.sv
module wrap_burst_seq
  import wbs_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int BANK_W = 2,
  parameter int LEN_W  = 5,
  localparam int MEM_W = ADDR_W - BANK_W,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrap,
  input  logic              cfgWide,
  input  logic              cfgSync,
  input  logic              cfgWrapEn,
  input  logic              cfgWrap16,
  output logic [MEM_W-1:0]  memAddr,
  output logic [NBANK-1:0]  memBankSel,
  output logic              addrValid,
  output logic              beatStrobe,
  output logic              txnStart,
  output logic              txnEnd,
  output logic              done
);
  ctlStrobes_t       ctl;
  logic [BANK_W-1:0] bankQ;
  logic              lastBeat;
  logic              splitPend;
  logic              syncQ;
  logic              busy;

  wbs_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .lastBeat   (lastBeat),
    .splitPend  (splitPend),
    .syncQ      (syncQ),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .busy       (busy),
    .addrValid  (addrValid),
    .beatStrobe (beatStrobe),
    .txnStart   (txnStart),
    .txnEnd     (txnEnd),
    .done       (done)
  );

  wbs_datapath #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .reqWrap   (reqWrap),
    .cfgWide   (cfgWide),
    .cfgSync   (cfgSync),
    .cfgWrapEn (cfgWrapEn),
    .cfgWrap16 (cfgWrap16),
    .curAddr   (memAddr),
    .bankQ     (bankQ),
    .lastBeat  (lastBeat),
    .splitPend (splitPend),
    .syncQ     (syncQ)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign memBankSel[g] = busy && (bankQ == BANK_W'(g));
  end
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
  parameter int MEM_W = 26,
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [MEM_W-1:0] memAddr,
  input logic [NBANK-1:0] memBankSel,
  input logic             addrValid,
  input logic             beatStrobe,
  input logic             txnStart,
  input logic             txnEnd,
  input logic             done
);
  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(memBankSel)); // R1
  AST_BANK_IDLE: assert property (@(posedge clk) disable iff (!rstN) reqReady |-> (memBankSel == '0)); // R1
  AST_BANK_BUSY: assert property (@(posedge clk) disable iff (!rstN) !reqReady |-> ($countones(memBankSel) == 1)); // R1
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqReady) |=> !reqReady); // R3
  AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqReady) |=> (addrValid && txnStart && !beatStrobe)); // R4
  AST_END_ON_BEAT: assert property (@(posedge clk) disable iff (!rstN) txnEnd |-> beatStrobe); // R4
  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rstN) (beatStrobe && !addrValid) |-> $stable(memAddr)); // R5
  AST_SPLIT_OR_DONE: assert property (@(posedge clk) disable iff (!rstN) txnEnd |=> (done || txnStart)); // R8
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rstN) done |-> ($past(txnEnd) && reqReady)); // R10
endmodule

bind wrap_burst_seq wbs_checker #(
  .MEM_W (MEM_W),
  .NBANK (NBANK)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .memAddr    (memAddr),
  .memBankSel (memBankSel),
  .addrValid  (addrValid),
  .beatStrobe (beatStrobe),
  .txnStart   (txnStart),
  .txnEnd     (txnEnd),
  .done       (done)
);

// File: tb/wrap_burst_seq_tb.sv
`timescale 1ns/1ps
module wrap_burst_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [27:0] reqAddr = '0;
  logic [4:0]  reqLen = 5'd1;
  logic        reqWrap = 1'b0;
  logic        cfgWide = 1'b0;
  logic        cfgSync = 1'b0;
  logic        cfgWrapEn = 1'b0;
  logic        cfgWrap16 = 1'b0;
  logic [25:0] memAddr;
  logic [3:0]  memBankSel;
  logic        addrValid, beatStrobe, txnStart, txnEnd, done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wrap_burst_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWrap(reqWrap), .cfgWide(cfgWide),
    .cfgSync(cfgSync), .cfgWrapEn(cfgWrapEn), .cfgWrap16(cfgWrap16),
    .memAddr(memAddr), .memBankSel(memBankSel), .addrValid(addrValid),
    .beatStrobe(beatStrobe), .txnStart(txnStart), .txnEnd(txnEnd), .done(done)
  );

  typedef struct packed {
    logic        av, bs, ts, te, dn, rdy;
    logic [25:0] addr;
    logic [3:0]  bank;
  } exp_t;

  exp_t expQ[$];

  // behavioural reference: expected output of every cycle after acceptance
  task automatic buildExp(input logic [27:0] a, input int len, input bit wrap,
                          input bit wide, input bit sync, input bit wEn, input bit n16);
    int word, mask, off, base, nWrap, nseg;
    int segStart[2];
    int segCnt[2];
    exp_t e;
    logic [3:0] bsel;
    word  = wide ? int'(a[25:1]) : int'(a[25:0]);
    bsel  = 4'b0001 << a[27:26];
    mask  = len - 1;
    off   = wrap ? (word & mask) : 0;
    base  = word - off;
    nWrap = n16 ? 16 : 8;
    if (wrap && sync && !(wEn && len == nWrap) && off != 0) begin
      nseg = 2; segStart[0] = word; segCnt[0] = len - off;
      segStart[1] = base; segCnt[1] = off;
    end else begin
      nseg = 1; segStart[0] = word; segCnt[0] = len;
      segStart[1] = 0; segCnt[1] = 0;
    end
    for (int s = 0; s < nseg; s++) begin
      e = '0; e.av = 1; e.ts = 1; e.addr = 26'(segStart[s]); e.bank = bsel;
      expQ.push_back(e);
      for (int k = 0; k < segCnt[s]; k++) begin
        int ak;
        ak = wrap ? base + ((segStart[s] - base + k) % len) : segStart[s] + k;
        e = '0; e.bs = 1; e.av = !sync; e.te = (k == segCnt[s] - 1);
        e.addr = sync ? 26'(segStart[s]) : 26'(ak); e.bank = bsel;
        expQ.push_back(e);
      end
    end
    e = '0; e.dn = 1; e.rdy = 1;
    expQ.push_back(e);
  endtask

  task automatic runReq(input string tag, input logic [27:0] a, input int len,
                        input bit wrap, input bit wide, input bit sync,
                        input bit wEn, input bit n16, input bit holdOff);
    exp_t e;
    bit first;
    buildExp(a, len, wrap, wide, sync, wEn, n16);
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqLen = 5'(len); reqWrap = wrap;
    cfgWide = wide; cfgSync = sync; cfgWrapEn = wEn; cfgWrap16 = n16;
    first = 1;
    while (expQ.size() > 0) begin
      @(negedge clk);
      e = expQ.pop_front();
      checks++;
      if (addrValid !== e.av || beatStrobe !== e.bs || txnStart !== e.ts ||
          txnEnd !== e.te || done !== e.dn || reqReady !== e.rdy ||
          memBankSel !== e.bank || ((e.av || e.bs) && memAddr !== e.addr)) begin
        fails++;
        $display("FAIL %s: got av%0b bs%0b ts%0b te%0b dn%0b rdy%0b bank%h addr%h, expected av%0b bs%0b ts%0b te%0b dn%0b rdy%0b bank%h addr%h",
                 tag, addrValid, beatStrobe, txnStart, txnEnd, done, reqReady, memBankSel, memAddr,
                 e.av, e.bs, e.ts, e.te, e.dn, e.rdy, e.bank, e.addr);
      end
      if (first) begin
        first = 0;
        if (holdOff) begin
          // R3: a second request and new settings while busy must change nothing
          reqAddr = a ^ 28'h8A5_5A5A; reqLen = 5'd2; reqWrap = !wrap;
          cfgWide = !wide; cfgSync = !sync; cfgWrapEn = !wEn; cfgWrap16 = !n16;
        end else begin
          reqValid = 0;
        end
      end
      if (expQ.size() == 1) reqValid = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;
    if (reqReady !== 1 || addrValid !== 0 || beatStrobe !== 0 || done !== 0 || memBankSel !== 0) begin
      fails++;
      $display("FAIL R1 R3 reset: rdy%0b av%0b bs%0b dn%0b bank%h, expected rdy1 av0 bs0 dn0 bank0",
               reqReady, addrValid, beatStrobe, done, memBankSel);
    end
    runReq("R2 R4 R6 linear async 8-bit bank0", 28'h000_1234, 4, 0, 0, 0, 0, 0, 0);
    runReq("R1 R2 R5 linear sync 16-bit bank2", 28'h800_0ABC, 8, 0, 1, 1, 0, 0, 0);
    runReq("R6 wrap async 16-bit", 28'h400_002A, 8, 1, 1, 0, 0, 0, 0);
    runReq("R7 wrap sync memory wraps N8", 28'hC00_0103, 8, 1, 0, 1, 1, 0, 0);
    runReq("R8 wrap sync split wrap off", 28'h000_0103, 8, 1, 0, 1, 0, 0, 0);
    runReq("R8 wrap sync split N16 len8", 28'h400_020C, 8, 1, 1, 1, 1, 1, 0);
    runReq("R9 wrap sync aligned", 28'h800_0540, 16, 1, 0, 1, 0, 0, 0);
    runReq("R8 R10 wrap sync split 1+15", 28'h000_247E, 16, 1, 1, 1, 0, 1, 0);
    runReq("R7 wrap sync memory wraps N16", 28'hC00_0035, 16, 1, 0, 1, 1, 1, 0);
    runReq("R3 held off while busy", 28'h400_0106, 8, 1, 0, 1, 0, 0, 1);
    runReq("R1 R10 single beat bank3", 28'hFFF_FFFF, 1, 0, 0, 0, 0, 0, 0);
    runReq("R6 wrap async len4 8-bit", 28'h000_0007, 4, 1, 0, 0, 0, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule